// File: doc/BRIEF.md
# Logarithmic-Number Multiply/Divide Unit

This block multiplies or divides two numbers held in a logarithmic number system. A value is kept as its sign and its base-2 logarithm, so a product becomes the sum of two logarithms and a quotient becomes their difference. A fixed-point adder/subtractor therefore does all the arithmetic work, and the result is exact whenever it stays in range.

The unit has no natural code for zero, infinity or not-a-number. A separate two-bit class field carries these values. A small rule table resolves the class combinations the way IEEE 754 multiply and divide do. A log sum or difference that leaves the representable range becomes signed infinity when too large and zero when too small.

One operation can be accepted on every clock. Its result appears on the registered output one cycle later, together with a valid strobe. The log field has `INT_W` integer bits and `FRAC_W` fraction bits, and both are parameters.

Top module: `lnsmd_unit`

## Requirements
- R1: An operand or result word is `{class[1:0], sign, log[INT_W+FRAC_W-1:0]}`, with the class in the top two bits and the sign just below them. The class codes are 00 zero, 01 normal, 10 infinity and 11 not-a-number. The log field is a two's-complement fixed-point value with `FRAC_W` fraction bits.
- R2: When `in_valid` is high on a rising edge, `out_valid` is high after that edge and `res_word` holds that operation's result. When `in_valid` is low, `out_valid` is low after the edge. Synchronous reset clears `out_valid` and `res_word` to 0.
- R3: With `op_div` = 0 and both operands normal, the result log is the sum of the two logs, with class normal, whenever the sum lies within the log field's range.
- R4: With `op_div` = 1 and both operands normal, the result log is the dividend log (`a_word`) minus the divisor log (`b_word`), with class normal, whenever the difference lies within range.
- R5: The result sign is the XOR of the two operand signs for every operation and every class.
- R6: A sum or difference above the largest log value, 2^(INT_W+FRAC_W-1)-1 in raw units, gives class infinity. The largest value itself stays normal.
- R7: A sum or difference below the smallest log value, -2^(INT_W+FRAC_W-1) in raw units, gives class zero. The smallest value itself stays normal.
- R8: If either operand is not-a-number, the result is not-a-number.
- R9: Zero times infinity (in either order), zero divided by zero and infinity divided by infinity give not-a-number.
- R10: In a multiply, a zero operand gives zero, and an infinity operand gives infinity, when R8 and R9 do not apply.
- R11: In a divide, a zero dividend or an infinite divisor gives zero. An infinite dividend or a zero divisor gives infinity. These hold when R8 and R9 do not apply.
- R12: Whenever the result class is not normal, the result log field is all zeros, whatever the operand log fields held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and mode are valid this cycle |
| op_div | input | 1 | 0 = multiply, 1 = divide (a / b) |
| a_word | input | INT_W+FRAC_W+3 | Multiplicand or dividend |
| b_word | input | INT_W+FRAC_W+3 | Multiplier or divisor |
| out_valid | output | 1 | Result valid |
| res_word | output | INT_W+FRAC_W+3 | Result word |

## Verification
The assertions check several rules on every cycle:
- the one-cycle valid timing;
- the XOR sign;
- not-a-number propagation;
- the rule that a multiply with a zero operand never returns a normal class;
- the cleared log field of every special result.

The exact value of a log sum or difference can be shown only by the bench's scenarios, which compare full result words against an independent model. The same holds for the exact range edges where a result flips to infinity or zero, and for the complete class table for multiply and divide.

// File: rtl/lnsmd_pkg.sv
package lnsmd_pkg;

  typedef enum logic [1:0] {
    LC_ZERO = 2'b00,
    LC_NORM = 2'b01,
    LC_INF  = 2'b10,
    LC_NAN  = 2'b11
  } lnsmd_class_e;

endpackage

// File: rtl/lnsmd_log_arith.sv
module lnsmd_log_arith #(
  parameter int LOG_W = 16
) (
  input  logic [LOG_W-1:0] lg_a,
  input  logic [LOG_W-1:0] lg_b,
  input  logic             do_sub,
  output logic [LOG_W-1:0] lg_res,
  output logic             too_big,
  output logic             too_small
);
  localparam int EXT_W = LOG_W + 1;

  logic [EXT_W-1:0] ext_a;
  logic [EXT_W-1:0] ext_b;
  logic [EXT_W-1:0] ext_r;

  always_comb begin
    ext_a = {lg_a[LOG_W-1], lg_a};
    ext_b = {lg_b[LOG_W-1], lg_b};
    if (do_sub) ext_r = ext_a - ext_b;
    else        ext_r = ext_a + ext_b;
    // guard bit disagrees with the top result bit when out of range
    too_big   = ~ext_r[EXT_W-1] &  ext_r[LOG_W-1];
    too_small =  ext_r[EXT_W-1] & ~ext_r[LOG_W-1];
    lg_res    = ext_r[LOG_W-1:0];
  end
endmodule

// File: rtl/lnsmd_class_rules.sv
module lnsmd_class_rules
  import lnsmd_pkg::*;
(
  input  lnsmd_class_e cls_a,
  input  lnsmd_class_e cls_b,
  input  logic         is_div,
  input  logic         rng_hi,
  input  logic         rng_lo,
  output lnsmd_class_e cls_out
);
  logic a_z, a_i, b_z, b_i, any_nan;

  always_comb begin
    a_z     = (cls_a == LC_ZERO);
    a_i     = (cls_a == LC_INF);
    b_z     = (cls_b == LC_ZERO);
    b_i     = (cls_b == LC_INF);
    any_nan = (cls_a == LC_NAN) | (cls_b == LC_NAN);

    if (any_nan) begin
      cls_out = LC_NAN;
    end else if (!is_div) begin
      if ((a_z & b_i) | (a_i & b_z)) cls_out = LC_NAN;
      else if (a_z | b_z)            cls_out = LC_ZERO;
      else if (a_i | b_i)            cls_out = LC_INF;
      else if (rng_hi)               cls_out = LC_INF;
      else if (rng_lo)               cls_out = LC_ZERO;
      else                           cls_out = LC_NORM;
    end else begin
      if ((a_z & b_z) | (a_i & b_i)) cls_out = LC_NAN;
      else if (a_z | b_i)            cls_out = LC_ZERO;
      else if (a_i | b_z)            cls_out = LC_INF;
      else if (rng_hi)               cls_out = LC_INF;
      else if (rng_lo)               cls_out = LC_ZERO;
      else                           cls_out = LC_NORM;
    end
  end
endmodule

// File: rtl/lnsmd_unit.sv
module lnsmd_unit
  import lnsmd_pkg::*;
#(
  parameter int INT_W  = 6,
  parameter int FRAC_W = 10
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  input  logic                         op_div,
  input  logic [INT_W+FRAC_W+2:0]      a_word,
  input  logic [INT_W+FRAC_W+2:0]      b_word,
  output logic                         out_valid,
  output logic [INT_W+FRAC_W+2:0]      res_word
);
  localparam int LOG_W  = INT_W + FRAC_W;
  localparam int WORD_W = LOG_W + 3;
  localparam int SGN_B  = LOG_W;

  lnsmd_class_e           cls_a, cls_b, cls_r;
  logic [LOG_W-1:0]       lg_sum;
  logic                   hi_ovf, lo_ovf;
  logic                   sgn_r;
  logic [WORD_W-1:0]      nxt_word;

  assign cls_a = lnsmd_class_e'(a_word[WORD_W-1:WORD_W-2]);
  assign cls_b = lnsmd_class_e'(b_word[WORD_W-1:WORD_W-2]);
  assign sgn_r = a_word[SGN_B] ^ b_word[SGN_B];

  lnsmd_log_arith #(.LOG_W(LOG_W)) u_arith (
    .lg_a      (a_word[LOG_W-1:0]),
    .lg_b      (b_word[LOG_W-1:0]),
    .do_sub    (op_div),
    .lg_res    (lg_sum),
    .too_big   (hi_ovf),
    .too_small (lo_ovf)
  );

  lnsmd_class_rules u_rules (
    .cls_a   (cls_a),
    .cls_b   (cls_b),
    .is_div  (op_div),
    .rng_hi  (hi_ovf),
    .rng_lo  (lo_ovf),
    .cls_out (cls_r)
  );

  always_comb begin
    if (cls_r == LC_NORM) nxt_word = {cls_r, sgn_r, lg_sum};
    else                  nxt_word = {cls_r, sgn_r, {LOG_W{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      res_word  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) res_word <= nxt_word;
    end
  end

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid); // R2
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid); // R2
  AST_SIGN_XOR: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (res_word[SGN_B] == ($past(a_word[SGN_B]) ^ $past(b_word[SGN_B])))); // R5
  AST_NAN_SPREADS: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (a_word[WORD_W-1:WORD_W-2] == 2'b11 || b_word[WORD_W-1:WORD_W-2] == 2'b11))
    |=> (res_word[WORD_W-1:WORD_W-2] == 2'b11)); // R8
  AST_MUL_ZERO_NOT_NORM: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !op_div && (a_word[WORD_W-1:WORD_W-2] == 2'b00 || b_word[WORD_W-1:WORD_W-2] == 2'b00))
    |=> (res_word[WORD_W-1:WORD_W-2] != 2'b01)); // R10
  AST_SPECIAL_LOG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (out_valid && res_word[WORD_W-1:WORD_W-2] != 2'b01) |-> (res_word[LOG_W-1:0] == '0)); // R12
endmodule

// File: tb/lnsmd_unit_tb.sv
module lnsmd_unit_tb;
  localparam int K  = 6;
  localparam int F  = 10;
  localparam int LW = K + F;
  localparam int W  = LW + 3;
  localparam int MAXV = (1 << (LW - 1)) - 1;
  localparam int MINV = -(1 << (LW - 1));

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         op_div = 1'b0;
  logic [W-1:0] a_word = '0;
  logic [W-1:0] b_word = '0;
  logic         out_valid;
  logic [W-1:0] res_word;

  int checks = 0;
  int errors = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  lnsmd_unit #(.INT_W(K), .FRAC_W(F)) u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .op_div(op_div),
    .a_word(a_word), .b_word(b_word), .out_valid(out_valid), .res_word(res_word)
  );

  function automatic logic [W-1:0] mk(input logic [1:0] c, input logic s, input int lg);
    logic [LW-1:0] t;
    t = lg[LW-1:0];
    return {c, s, t};
  endfunction

  // independent reference from the requirements
  function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b, input logic dv);
    logic [1:0] ca, cb, cr;
    logic s;
    int la, lb, r;
    ca = a[W-1:W-2]; cb = b[W-1:W-2];
    s  = a[LW] ^ b[LW];
    la = int'($signed(a[LW-1:0]));
    lb = int'($signed(b[LW-1:0]));
    r  = dv ? la - lb : la + lb;
    if (ca == 2'b11 || cb == 2'b11) cr = 2'b11;
    else if (!dv && ((ca == 2'b00 && cb == 2'b10) || (ca == 2'b10 && cb == 2'b00))) cr = 2'b11;
    else if (dv && ca == cb && ca != 2'b01) cr = 2'b11;
    else if (!dv && (ca == 2'b00 || cb == 2'b00)) cr = 2'b00;
    else if (!dv && (ca == 2'b10 || cb == 2'b10)) cr = 2'b10;
    else if (dv && (ca == 2'b00 || cb == 2'b10)) cr = 2'b00;
    else if (dv && (ca == 2'b10 || cb == 2'b00)) cr = 2'b10;
    else if (r > MAXV) cr = 2'b10;
    else if (r < MINV) cr = 2'b00;
    else cr = 2'b01;
    return (cr == 2'b01) ? mk(cr, s, r) : mk(cr, s, 0);
  endfunction

  task automatic send(input logic [W-1:0] a, input logic [W-1:0] b, input logic dv,
                      input logic [W-1:0] expv, input string tag);
    @(negedge clk);
    a_word = a; b_word = b; op_div = dv; in_valid = 1'b1;
    exp_q.push_back(expv);
    tag_q.push_back(tag);
  endtask

  task automatic op(input logic [W-1:0] a, input logic [W-1:0] b, input logic dv, input string tag);
    send(a, b, dv, model(a, b, dv), tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected result actual=%h expected=none", res_word);
      end else begin
        logic [W-1:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (res_word !== e) begin
          errors++;
          $display("FAIL %s actual=%h expected=%h", t, res_word, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R2 watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || res_word !== '0) begin
      errors++;
      $display("FAIL R2 reset state actual=%b/%h expected=0/0", out_valid, res_word);
    end
    rst = 1'b0;

    // R1 R3 R5: normal multiplies, spot-checked with hand values too
    send(mk(2'b01, 0, 300), mk(2'b01, 1, 500), 0, mk(2'b01, 1, 800), "R3 mul sum, R1 layout");
    send(mk(2'b01, 1, -1000), mk(2'b01, 1, 250), 0, mk(2'b01, 0, -750), "R5 sign xor mul");
    // R4 divide
    send(mk(2'b01, 0, 1000), mk(2'b01, 0, 3000), 1, mk(2'b01, 0, -2000), "R4 div diff");
    send(mk(2'b01, 1, -5), mk(2'b01, 0, -7), 1, mk(2'b01, 1, 2), "R4 div neg logs, R5");
    // R6 upper edge
    op(mk(2'b01, 0, 30000), mk(2'b01, 0, 2767), 0, "R6 mul at max stays normal");
    send(mk(2'b01, 0, 30000), mk(2'b01, 1, 2768), 0, mk(2'b10, 1, 0), "R6 mul overflow to inf");
    send(mk(2'b01, 0, 30000), mk(2'b01, 0, -2768), 1, mk(2'b10, 0, 0), "R6 div overflow to inf");
    // R7 lower edge
    op(mk(2'b01, 0, -30000), mk(2'b01, 0, -2768), 0, "R7 mul at min stays normal");
    send(mk(2'b01, 1, -30000), mk(2'b01, 0, -2769), 0, mk(2'b00, 1, 0), "R7 mul underflow to zero");
    send(mk(2'b01, 0, -30000), mk(2'b01, 0, 2769), 1, mk(2'b00, 0, 0), "R7 div underflow to zero");
    // R8 NaN
    send(mk(2'b11, 0, 77), mk(2'b01, 1, 5), 0, mk(2'b11, 1, 0), "R8 nan a mul");
    send(mk(2'b00, 0, 0), mk(2'b11, 0, 9), 1, mk(2'b11, 0, 0), "R8 nan b div");
    // R9 invalid combos
    send(mk(2'b00, 1, 12), mk(2'b10, 0, 3), 0, mk(2'b11, 1, 0), "R9 zero*inf");
    send(mk(2'b10, 0, 0), mk(2'b00, 0, 0), 0, mk(2'b11, 0, 0), "R9 inf*zero");
    send(mk(2'b00, 0, 0), mk(2'b00, 1, 0), 1, mk(2'b11, 1, 0), "R9 zero/zero");
    send(mk(2'b10, 1, 0), mk(2'b10, 1, 0), 1, mk(2'b11, 0, 0), "R9 inf/inf");
    // R10 multiply with specials, R12 junk log ignored
    send(mk(2'b00, 0, 555), mk(2'b01, 1, 100), 0, mk(2'b00, 1, 0), "R10 zero*normal, R12");
    send(mk(2'b01, 1, 100), mk(2'b10, 1, 321), 0, mk(2'b10, 0, 0), "R10 normal*inf, R12");
    send(mk(2'b10, 0, 0), mk(2'b10, 1, 0), 0, mk(2'b10, 1, 0), "R10 inf*inf");
    // R11 divide with specials
    send(mk(2'b01, 0, 40), mk(2'b00, 0, 0), 1, mk(2'b10, 0, 0), "R11 normal/zero");
    send(mk(2'b01, 1, 40), mk(2'b10, 0, 0), 1, mk(2'b00, 1, 0), "R11 normal/inf");
    send(mk(2'b00, 0, 0), mk(2'b01, 0, 99), 1, mk(2'b00, 0, 0), "R11 zero/normal");
    send(mk(2'b10, 0, 0), mk(2'b01, 1, 99), 1, mk(2'b10, 1, 0), "R11 inf/normal");
    send(mk(2'b00, 0, 0), mk(2'b10, 0, 0), 1, mk(2'b00, 0, 0), "R11 zero/inf");
    send(mk(2'b10, 0, 0), mk(2'b00, 0, 0), 1, mk(2'b10, 0, 0), "R11 inf/zero");
    // back-to-back sweep through the model
    for (int i = 0; i < 40; i++) begin
      int x, y;
      x = (i * 1237) % 65536 - 32768;
      y = (i * 4099 + 77) % 65536 - 32768;
      op(mk(2'b01, i[0], x), mk(2'b01, i[1], y), i[2], "R3 R4 R6 R7 sweep");
    end
    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || exp_q.size() != 0) begin
      errors++;
      $display("FAIL R2 idle actual=%b/%0d expected=0/0", out_valid, exp_q.size());
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule